// File: doc/BRIEF.md
# Edge-Detecting Interrupt Controller

This block merges up to 32 interrupt request lines into one interrupt output. Each line is sampled on every clock and handled in one of two ways. In edge mode a 0-to-1 transition of the line is an event. In level mode the line counts as an event on every cycle it is high. An event reaches the sticky pending register only if the line's admit bit allows it. A pending bit reaches the output only if the line's forward bit allows it. The output is either a level that stays high while any forwarded bit is pending, or a one-cycle strobe on each new rise of that condition.

Software reaches the controller through a small word-wide register bus. A request with the write flag set updates a register on the same clock edge. A read request returns data, with a valid flag, one clock later. Pending bits are acknowledged by writing ones to an acknowledge register. Zeros in that write leave their lines untouched, so lines can be acknowledged one at a time.

Top module: `irqc_top`

## Requirements
- R1: After reset every register reads 0, `irq_out` is low and `rd_valid` is low.
- R2: The line-mode (index 0), admit (index 1), forward (index 3) and output-mode (index 5) registers read back the last value written to them. Output-mode stores only bit 0, and its other bits read 0. A read request returns its data with `rd_valid` high exactly one cycle later. The data already reflects every write accepted in an earlier cycle.
- R3: A line whose line-mode bit is 1 sets its pending bit only on a 0-to-1 change between two consecutive clock samples. A line held high after its pending bit is acknowledged does not set it again.
- R4: A line whose line-mode bit is 0 sets its pending bit on every cycle it is high, so acknowledging it while it is still high leaves the bit set.
- R5: A line whose admit bit is 0 never sets its pending bit. A pending bit that is already set stays set when its admit bit is cleared.
- R6: A write to the acknowledge register (index 4) clears each pending bit whose data bit is 1 and leaves the others unchanged. Writing all ones clears every line.
- R7: The pending register (index 2) holds one bit per line and shows several pending lines at the same time.
- R8: A pending line whose forward bit is 0 does not raise `irq_out`.
- R9: With output-mode bit 0 cleared, `irq_out` goes high one cycle after a forwarded line becomes pending. It goes low one cycle after no forwarded line is pending.
- R10: With output-mode bit 0 set, `irq_out` is high for exactly one cycle on each 0-to-1 change of "any forwarded line pending". There is no further strobe while that condition stays high.
- R11: When an acknowledge and a new event hit the same line in the same cycle, the pending bit stays set.
- R12: Writes to the pending register are ignored, and the acknowledge register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, valid when rd_valid is high |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| irq_lines | input | N_CH | Interrupt request lines, synchronous to clk |
| irq_out | output | 1 | Combined interrupt output |

## Verification
Several properties are checked on every cycle:
- A pending bit never appears while its line's admit bit is 0.
- A pending bit never drops in a cycle without an acknowledge of that bit.
- `irq_out` is only high after a cycle in which some forwarded line was pending.
- In strobe mode the output is never high for two cycles in a row.
- Read data is flagged valid exactly one cycle after each read request, and never otherwise.

Only the bench scenarios can show the following:
- The edge and level line modes behave differently after an acknowledge.
- An event wins over an acknowledge in the same cycle.
- Register read-back values are correct.
- Strobe count per rise is exactly one, and there is no strobe while the condition stays high.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    IDX_LMODE = 3'd0,
    IDX_ADMIT = 3'd1,
    IDX_PEND  = 3'd2,
    IDX_FWD   = 3'd3,
    IDX_ACK   = 3'd4,
    IDX_OMODE = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N_CH   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [N_CH-1:0]   pend_i,
  output logic [N_CH-1:0]   lmode_o,
  output logic [N_CH-1:0]   admit_o,
  output logic [N_CH-1:0]   fwd_o,
  output logic              strobe_o,
  output logic [N_CH-1:0]   ack_o,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [N_CH-1:0]   lmode_q, admit_q, fwd_q;
  logic              omode_q;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              rval_q;
  logic              wr_acc, rd_acc;
  logic              we_lmode, we_admit, we_fwd, we_omode;
  reg_idx_e          idx;

  assign idx    = reg_idx_e'(bus_addr);
  assign wr_acc = bus_req & bus_wr;
  assign rd_acc = bus_req & ~bus_wr;

  always_comb begin
    we_lmode = wr_acc & (idx == IDX_LMODE);
    we_admit = wr_acc & (idx == IDX_ADMIT);
    we_fwd   = wr_acc & (idx == IDX_FWD);
    we_omode = wr_acc & (idx == IDX_OMODE);
    ack_o    = (wr_acc & (idx == IDX_ACK)) ? bus_wdata[N_CH-1:0] : '0;
  end

  always_comb begin
    rdat_d = '0;
    unique case (idx)
      IDX_LMODE: rdat_d[N_CH-1:0] = lmode_q;
      IDX_ADMIT: rdat_d[N_CH-1:0] = admit_q;
      IDX_PEND:  rdat_d[N_CH-1:0] = pend_i;
      IDX_FWD:   rdat_d[N_CH-1:0] = fwd_q;
      IDX_OMODE: rdat_d[0]        = omode_q;
      default:   rdat_d           = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lmode_q <= '0;
      admit_q <= '0;
      fwd_q   <= '0;
      omode_q <= 1'b0;
      rdat_q  <= '0;
      rval_q  <= 1'b0;
    end else begin
      if (we_lmode) lmode_q <= bus_wdata[N_CH-1:0];
      if (we_admit) admit_q <= bus_wdata[N_CH-1:0];
      if (we_fwd)   fwd_q   <= bus_wdata[N_CH-1:0];
      if (we_omode) omode_q <= bus_wdata[0];
      if (rd_acc)   rdat_q  <= rdat_d;
      rval_q <= rd_acc;
    end
  end

  assign lmode_o  = lmode_q;
  assign admit_o  = admit_q;
  assign fwd_o    = fwd_q;
  assign strobe_o = omode_q;
  assign rd_data  = rval_q ? rdat_q : '0;
  assign rd_valid = rval_q;
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
  parameter int N_CH = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] lines_i,
  input  logic [N_CH-1:0] lmode_i,
  input  logic [N_CH-1:0] admit_i,
  output logic [N_CH-1:0] evt_o
);
  logic [N_CH-1:0] prev_q;
  logic [N_CH-1:0] raw;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    always_comb begin
      if (lmode_i[g]) raw[g] = lines_i[g] & ~prev_q[g];
      else            raw[g] = lines_i[g];
    end
    assign evt_o[g] = raw[g] & admit_i[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lines_i;
  end
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
  parameter int N_CH = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] evt_i,
  input  logic [N_CH-1:0] ack_i,
  output logic [N_CH-1:0] pend_o
);
  logic [N_CH-1:0] pend_q, pend_d;
  logic            upd;

  always_comb begin
    pend_d = (pend_q & ~ack_i) | evt_i;
    upd    = (|evt_i) | (|ack_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (upd) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqc_out.sv
module irqc_out #(
  parameter int N_CH = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] pend_i,
  input  logic [N_CH-1:0] fwd_i,
  input  logic            strobe_i,
  output logic            irq_o
);
  logic act, act_q, out_d, out_q;

  always_comb begin
    act   = |(pend_i & fwd_i);
    out_d = strobe_i ? (act & ~act_q) : act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      act_q <= act;
      out_q <= out_d;
    end
  end

  assign irq_o = out_q;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N_CH   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic [N_CH-1:0]   irq_lines,
  output logic              irq_out
);
  logic [N_CH-1:0] lmode_w, admit_w, fwd_w, ack_w, evt_w, pend_w;
  logic            strobe_w;

  irqc_regs #(.N_CH(N_CH), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend_i(pend_w),
    .lmode_o(lmode_w), .admit_o(admit_w), .fwd_o(fwd_w),
    .strobe_o(strobe_w), .ack_o(ack_w), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  irqc_detect #(.N_CH(N_CH)) u_det (
    .clk(clk), .rst_n(rst_n), .lines_i(irq_lines), .lmode_i(lmode_w),
    .admit_i(admit_w), .evt_o(evt_w)
  );

  irqc_pend #(.N_CH(N_CH)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_w), .ack_i(ack_w), .pend_o(pend_w)
  );

  irqc_out #(.N_CH(N_CH)) u_out (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_w), .fwd_i(fwd_w),
    .strobe_i(strobe_w), .irq_o(irq_out)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N_CH = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_req,
  input logic            bus_wr,
  input logic            rd_valid,
  input logic [N_CH-1:0] pend,
  input logic [N_CH-1:0] admit,
  input logic [N_CH-1:0] fwd,
  input logic [N_CH-1:0] ack,
  input logic            strobe,
  input logic            irq_out
);
  a_r5_no_latch_unadmitted: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(admit)) == '0));

  a_r6_drop_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend) & ~pend & ~$past(ack)) == '0));

  a_r8_out_needs_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(|(pend & fwd)));

  a_r10_single_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobe) && $past(strobe, 2)) |-> !(irq_out && $past(irq_out)));

  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr) |=> rd_valid);

  a_r2_valid_only_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_req && !bus_wr));
endmodule

bind irqc_top irqc_checker #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
  .rd_valid(rd_valid), .pend(pend_w), .admit(admit_w), .fwd(fwd_w),
  .ack(ack_w), .strobe(strobe_w), .irq_out(irq_out)
);

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;
  localparam logic [2:0] A_LMODE = 3'd0, A_ADMIT = 3'd1, A_PEND = 3'd2,
                         A_FWD = 3'd3, A_ACK = 3'd4, A_OMODE = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, rd_data, irq_lines;
  logic        rd_valid, irq_out;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  irqc_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .irq_lines(irq_lines), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    check("R2 rd_valid one cycle after read", {31'd0, rd_valid}, 32'd1);
    d = rd_data;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic line_pulse(input logic [31:0] v);
    @(negedge clk); irq_lines = v;
    @(negedge clk); irq_lines = '0;
  endtask

  task automatic count_out(input int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (irq_out) cnt++;
    end
  endtask

  task automatic t_reset;
    check("R1 irq_out low", {31'd0, irq_out}, 32'd0);
    check("R1 rd_valid low", {31'd0, rd_valid}, 32'd0);
    for (int i = 0; i < 6; i++) rd_chk("R1 register zero", 3'(i), 32'd0);
  endtask

  task automatic t_regs;
    wr(A_LMODE, 32'hA5A5_0F0F); rd_chk("R2 line-mode readback", A_LMODE, 32'hA5A5_0F0F);
    wr(A_ADMIT, 32'h1234_8765); rd_chk("R2 admit readback", A_ADMIT, 32'h1234_8765);
    wr(A_FWD, 32'hDEAD_BEEF);   rd_chk("R2 forward readback", A_FWD, 32'hDEAD_BEEF);
    wr(A_FWD, 32'h0000_0001);   rd_chk("R2 forward after rewrite", A_FWD, 32'h1);
    wr(A_OMODE, 32'hFFFF_FFFF); rd_chk("R2 output-mode bit0 only", A_OMODE, 32'h1);
    wr(A_OMODE, 32'h0);
    rd_chk("R12 acknowledge reads zero", A_ACK, 32'h0);
    wr(A_LMODE, 32'h0); wr(A_ADMIT, 32'hFFFF_FFFF); wr(A_FWD, 32'h0);
  endtask

  task automatic t_level;
    wr(A_ACK, 32'hFFFF_FFFF);
    line_pulse(32'h0000_0088);
    rd_chk("R7 two lines pending", A_PEND, 32'h88);
    wr(A_ACK, 32'h0000_0008);
    rd_chk("R6 single-bit acknowledge", A_PEND, 32'h80);
    wr(A_PEND, 32'hFFFF_FFFF);
    rd_chk("R12 pending write ignored", A_PEND, 32'h80);
    @(negedge clk); irq_lines = 32'h8;
    wr(A_ACK, 32'h8);
    rd_chk("R4 level relatches while high", A_PEND, 32'h88);
    irq_lines = '0;
    line_pulse(32'hF000_0001);
    wr(A_ACK, 32'hFFFF_FFFF);
    rd_chk("R6 all-ones clears every line", A_PEND, 32'h0);
  endtask

  task automatic t_edge;
    wr(A_LMODE, 32'h0000_0020);
    @(negedge clk); irq_lines = 32'h20;
    rd_chk("R3 rising edge latches", A_PEND, 32'h20);
    wr(A_ACK, 32'h20);
    rd_chk("R3 held line does not relatch", A_PEND, 32'h0);
    @(negedge clk); irq_lines = '0;
    @(negedge clk); irq_lines = 32'h20;
    rd_chk("R3 new rise latches again", A_PEND, 32'h20);
    irq_lines = '0;
    wr(A_ACK, 32'hFFFF_FFFF);
  endtask

  task automatic t_clash;
    wr(A_LMODE, 32'h0000_0010);
    line_pulse(32'h10);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = A_ACK; bus_wdata = 32'h10;
    irq_lines = 32'h10;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0; irq_lines = '0;
    rd_chk("R11 event wins over acknowledge", A_PEND, 32'h10);
    wr(A_ACK, 32'hFFFF_FFFF); wr(A_LMODE, 32'h0);
  endtask

  task automatic t_admit;
    wr(A_ADMIT, ~32'h0000_0200);
    line_pulse(32'h200);
    rd_chk("R5 unadmitted line not latched", A_PEND, 32'h0);
    wr(A_ADMIT, 32'hFFFF_FFFF);
    line_pulse(32'h200);
    wr(A_ADMIT, ~32'h0000_0200);
    rd_chk("R5 pending kept after admit cleared", A_PEND, 32'h200);
    wr(A_ACK, 32'hFFFF_FFFF); wr(A_ADMIT, 32'hFFFF_FFFF);
  endtask

  task automatic t_level_out;
    int cnt;
    line_pulse(32'h4);
    count_out(3, cnt);
    check("R8 unforwarded pending keeps output low", cnt, 0);
    wr(A_FWD, 32'h4);
    @(negedge clk);
    check("R9 level output high", {31'd0, irq_out}, 32'd1);
    wr(A_FWD, 32'h8);
    @(negedge clk);
    check("R8 output drops when forward cleared", {31'd0, irq_out}, 32'd0);
    wr(A_FWD, 32'h4);
    wr(A_ACK, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R9 level output low after acknowledge", {31'd0, irq_out}, 32'd0);
  endtask

  task automatic t_pulse;
    int cnt;
    wr(A_OMODE, 32'hFFFF_FFFF);
    count_out(3, cnt);
    check("R10 no strobe while idle", cnt, 0);
    line_pulse(32'h4);
    count_out(8, cnt);
    check("R10 one strobe per rise", cnt, 1);
    line_pulse(32'h4);
    count_out(8, cnt);
    check("R10 no strobe while still pending", cnt, 0);
    wr(A_ACK, 32'hFFFF_FFFF);
    line_pulse(32'h4);
    count_out(8, cnt);
    check("R10 strobe after acknowledge and new event", cnt, 1);
    wr(A_ACK, 32'hFFFF_FFFF); wr(A_OMODE, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; irq_lines = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_level;
    t_edge;
    t_clash;
    t_admit;
    t_level_out;
    t_pulse;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule